// File: doc/BRIEF.md
# Multi-Queue Transmit Descriptor Ring Engine

This engine serves several transmit rings held in system memory. On a start pulse it visits each ring, beginning with the highest-numbered queue and ending with queue 0. For every descriptor that hardware owns, it copies the buffer fragment byte by byte into a local 2048-byte frame store. When a descriptor marks the end of a frame, the engine returns ownership by setting the used bit on that frame's first descriptor. It then streams the gathered frame out on a byte-wide valid/ready channel.

Each descriptor is two 32-bit words at consecutive addresses, and successive descriptors are 8 bytes apart:
- Word 0 holds the buffer byte address.
- Word 1 holds the fragment length in bits [13:0], the end-of-frame flag in bit 15, the wrap flag in bit 30 and the used flag in bit 31.

Memory is reached through a single word port with a fixed read latency of one cycle. Software loads each ring base through a per-queue write strobe. It also sets the enable, loopback and mask inputs, and reads the sticky status and interrupt outputs.

Status and interrupt bits are indexed the same way: bit 0 is frame-complete and bit 1 is used-descriptor-reached. `irq_o` is the OR of all unmasked interrupt bits.

Top module: `txr_engine`

## Requirements
- R1: Descriptors of a ring are read at the current address and at address+4, and the next descriptor of the same ring is at address+8.
- R2: A pass serves queues in descending index order, NQ-1 first and 0 last, so frames of a higher queue leave before those of a lower one.
- R3: A descriptor with bit 31 of word 1 set ends that queue. It sets `stat_o[1]`, and sets `isr_o[1]` only when `glb_msk_i[1]` is 0.
- R4: If `tx_en_i` is 0 when a hardware-owned descriptor is evaluated, the whole pass ends at once. No frame is sent, no descriptor is written back, and no later queue is visited.
- R5: A descriptor with buffer address 0 or length 0 stops its queue without sending anything.
- R6: A fragment longer than the free space in the 2048-byte frame store stops its queue without copying any byte.
- R7: Fragments are appended in ring order, and the emitted frame is their concatenation, with length equal to the sum of the fragment lengths.
- R8: On an end-of-frame descriptor, word 1 of the frame's first descriptor is read, written back with bit 31 set, and only then is the frame emitted. Other descriptors of the frame are not modified.
- R9: After a frame completes, the queue's frame-start pointer becomes the ring base if the last descriptor had bit 30 set, and otherwise that descriptor's address+8.
- R10: Frame completion sets `stat_o[0]`, and sets `isr_o[0]` only when `glb_msk_i[0]` is 0. With more than one queue it also sets `q_isr_o[q]` only when `q_msk_i[q]` is 0.
- R11: With `loopback_i` high at completion, the frame goes out on the `lb_*` channel instead of `tx_*`.
- R12: A byte is held stable while ready is low, and `tlast` is high on exactly the final byte of each frame.
- R13: Reset and a `stat_clr_i` pulse leave all status and interrupt outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins a transmit pass |
| tx_en_i | input | 1 | Transmit enable |
| loopback_i | input | 1 | Route frames to the loopback channel |
| base_we_i | input | NQ | Per-queue strobe loading ring base and frame-start pointer |
| ring_base_i | input | NQ*AW | Ring base addresses, queue q at bits [q*AW +: AW] |
| glb_msk_i | input | 2 | Global interrupt masks (bit0 complete, bit1 used) |
| q_msk_i | input | NQ | Per-queue completion interrupt masks |
| stat_clr_i | input | 1 | Clears status and interrupt bits |
| busy_o | output | 1 | Pass in progress |
| stat_o | output | 2 | Sticky status (bit0 complete, bit1 used) |
| isr_o | output | 2 | Global interrupt status |
| q_isr_o | output | NQ | Per-queue interrupt status |
| irq_o | output | 1 | OR of all interrupt status bits |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| tx_tdata_o | output | 8 | Transmit byte |
| tx_tvalid_o | output | 1 | Transmit byte valid |
| tx_tlast_o | output | 1 | Final byte of frame |
| tx_tready_i | input | 1 | Transmit sink ready |
| lb_tdata_o | output | 8 | Loopback byte |
| lb_tvalid_o | output | 1 | Loopback byte valid |
| lb_tlast_o | output | 1 | Final loopback byte |
| lb_tready_i | input | 1 | Loopback sink ready |

## Verification
The engine's results appear at different times after a start pulse:
- `busy_o` rises on the first clock edge after the pulse.
- Each descriptor costs three cycles to fetch and one to evaluate.
- Each copied byte costs two cycles.
- The ownership write-back lands one cycle after its read.
- Frame bytes follow immediately, one per cycle of ready.

The stream is recorded at the falling edge, with the same ready value the following rising edge will use, so every captured byte is one that was actually accepted. Memory contents, status and interrupt outputs are compared only after `busy_o` has fallen, when all write-backs and status updates of the pass have settled.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_LD, S_EVAL, S_CP_RQ, S_CP_WT,
    S_FS_RQ, S_FS_WT, S_EMIT, S_ADV, S_QNXT
  } txr_st_e;

  localparam int LEN_W  = 14;
  localparam int LAST_B = 15;
  localparam int WRAP_B = 30;
  localparam int USED_B = 31;
endpackage

// File: rtl/txr_fbuf.sv
`timescale 1ns/1ps
module txr_fbuf #(
  parameter int DEPTH = 2048,
  parameter int BW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [BW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [BW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/txr_irq.sv
`timescale 1ns/1ps
module txr_irq #(
  parameter int NQ = 2,
  parameter int QW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ev_cmpl_i,
  input  logic          ev_used_i,
  input  logic [QW-1:0] ev_q_i,
  input  logic [1:0]    glb_msk_i,
  input  logic [NQ-1:0] q_msk_i,
  output logic [1:0]    stat_o,
  output logic [1:0]    isr_o,
  output logic [NQ-1:0] q_isr_o,
  output logic          irq_o
);
  logic [1:0] stat_q, isr_q;
  logic [NQ-1:0] q_isr;

  // set wins over a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      isr_q  <= '0;
    end else begin
      if (clr_i) begin
        stat_q <= '0;
        isr_q  <= '0;
      end
      if (ev_cmpl_i) begin
        stat_q[0] <= 1'b1;
        if (!glb_msk_i[0]) isr_q[0] <= 1'b1;
      end
      if (ev_used_i) begin
        stat_q[1] <= 1'b1;
        if (!glb_msk_i[1]) isr_q[1] <= 1'b1;
      end
    end
  end

  if (NQ > 1) begin : g_qisr
    logic [NQ-1:0] q_isr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_isr_q <= '0;
      else begin
        if (clr_i) q_isr_q <= '0;
        for (int i = 0; i < NQ; i++)
          if (ev_cmpl_i && ev_q_i == QW'(i) && !q_msk_i[i]) q_isr_q[i] <= 1'b1;
      end
    end
    assign q_isr = q_isr_q;
  end else begin : g_noq
    assign q_isr = '0;
  end

  assign stat_o  = stat_q;
  assign isr_o   = isr_q;
  assign q_isr_o = q_isr;
  assign irq_o   = |{isr_q, q_isr};

  // R10
  cmpl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isr_q[0]) |-> !$past(glb_msk_i[0]));
endmodule

// File: rtl/txr_engine.sv
`timescale 1ns/1ps
module txr_engine
  import txr_pkg::*;
#(
  parameter int NQ       = 2,
  parameter int AW       = 32,
  parameter int FB_BYTES = 2048
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           tx_en_i,
  input  logic           loopback_i,
  input  logic [NQ-1:0]  base_we_i,
  input  logic [NQ*AW-1:0] ring_base_i,
  input  logic [1:0]     glb_msk_i,
  input  logic [NQ-1:0]  q_msk_i,
  input  logic           stat_clr_i,
  output logic           busy_o,
  output logic [1:0]     stat_o,
  output logic [1:0]     isr_o,
  output logic [NQ-1:0]  q_isr_o,
  output logic           irq_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic [31:0]    mem_rdata_i,
  output logic [7:0]     tx_tdata_o,
  output logic           tx_tvalid_o,
  output logic           tx_tlast_o,
  input  logic           tx_tready_i,
  output logic [7:0]     lb_tdata_o,
  output logic           lb_tvalid_o,
  output logic           lb_tlast_o,
  input  logic           lb_tready_i
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int PW = $clog2(FB_BYTES + 1);
  localparam int BW = $clog2(FB_BYTES);

  txr_st_e          state_q;
  logic [QW-1:0]    q_q;
  logic [AW-1:0]    cur_q;
  logic [AW-1:0]    fs_q   [NQ];
  logic [AW-1:0]    base_q [NQ];
  logic [31:0]      w0_q, w1_q;
  logic [LEN_W-1:0] cnt_q;
  logic [PW-1:0]    wptr_q, rd_q;
  logic             lb_q;

  logic [LEN_W-1:0] len;
  logic             d_used, d_last, d_wrap, bad, oversize;
  logic [AW-1:0]    src, nxt;
  logic             emit, last_beat, strm_rdy;
  logic [7:0]       fb_rd;

  assign len      = w1_q[LEN_W-1:0];
  assign d_used   = w1_q[USED_B];
  assign d_last   = w1_q[LAST_B];
  assign d_wrap   = w1_q[WRAP_B];
  assign bad      = (w0_q == '0) || (len == '0);
  assign oversize = int'(len) > (FB_BYTES - int'(wptr_q));
  assign src      = w0_q[AW-1:0] + AW'(cnt_q);
  assign nxt      = d_wrap ? base_q[q_q] : cur_q + AW'(8);

  assign emit      = (state_q == S_EMIT);
  assign last_beat = (rd_q == wptr_q - PW'(1));
  assign strm_rdy  = lb_q ? lb_tready_i : tx_tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      q_q     <= '0;
      cur_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      cnt_q   <= '0;
      wptr_q  <= '0;
      rd_q    <= '0;
      lb_q    <= 1'b0;
      for (int i = 0; i < NQ; i++) begin
        fs_q[i]   <= '0;
        base_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (base_we_i[i]) begin
          base_q[i] <= ring_base_i[i*AW +: AW];
          fs_q[i]   <= ring_base_i[i*AW +: AW];
        end
      end
      case (state_q)
        S_IDLE: if (start_i) begin
          q_q     <= QW'(NQ - 1);
          cur_q   <= fs_q[NQ-1];
          state_q <= S_RD0;
        end
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          w0_q    <= mem_rdata_i;
          state_q <= S_LD;
        end
        S_LD: begin
          w1_q    <= mem_rdata_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (d_used)                state_q <= S_QNXT;
          else if (!tx_en_i)         state_q <= S_IDLE;
          else if (bad || oversize)  state_q <= S_QNXT;
          else begin
            cnt_q   <= '0;
            state_q <= S_CP_RQ;
          end
        end
        S_CP_RQ: state_q <= S_CP_WT;
        S_CP_WT: begin
          wptr_q <= wptr_q + PW'(1);
          cnt_q  <= cnt_q + LEN_W'(1);
          if (cnt_q == len - LEN_W'(1)) state_q <= d_last ? S_FS_RQ : S_ADV;
          else                          state_q <= S_CP_RQ;
        end
        S_FS_RQ: state_q <= S_FS_WT;
        S_FS_WT: begin
          fs_q[q_q] <= nxt;
          lb_q      <= loopback_i;
          rd_q      <= '0;
          state_q   <= S_EMIT;
        end
        S_EMIT: if (strm_rdy) begin
          if (last_beat) begin
            wptr_q  <= '0;
            state_q <= S_ADV;
          end else begin
            rd_q <= rd_q + PW'(1);
          end
        end
        S_ADV: begin
          cur_q   <= nxt;
          state_q <= S_RD0;
        end
        S_QNXT: begin
          if (q_q == '0) state_q <= S_IDLE;
          else begin
            q_q     <= q_q - QW'(1);
            cur_q   <= fs_q[q_q - QW'(1)];
            state_q <= S_RD0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      S_RD0: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q;
      end
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(4);
      end
      S_CP_RQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {src[AW-1:2], 2'b00};
      end
      S_FS_RQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = fs_q[q_q] + AW'(4);
      end
      S_FS_WT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = fs_q[q_q] + AW'(4);
        mem_wdata_o = mem_rdata_i | (32'h1 << USED_B);
      end
      default: ;
    endcase
  end

  txr_fbuf #(.DEPTH(FB_BYTES), .BW(BW)) u_fbuf (
    .clk_i     (clk_i),
    .wr_en_i   (state_q == S_CP_WT),
    .wr_addr_i (wptr_q[BW-1:0]),
    .wr_data_i (mem_rdata_i[{src[1:0], 3'b000} +: 8]),
    .rd_addr_i (rd_q[BW-1:0]),
    .rd_data_o (fb_rd)
  );

  txr_irq #(.NQ(NQ), .QW(QW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (stat_clr_i),
    .ev_cmpl_i (state_q == S_FS_WT),
    .ev_used_i ((state_q == S_EVAL) && d_used),
    .ev_q_i    (q_q),
    .glb_msk_i (glb_msk_i),
    .q_msk_i   (q_msk_i),
    .stat_o    (stat_o),
    .isr_o     (isr_o),
    .q_isr_o   (q_isr_o),
    .irq_o     (irq_o)
  );

  assign busy_o      = (state_q != S_IDLE);
  assign tx_tdata_o  = fb_rd;
  assign lb_tdata_o  = fb_rd;
  assign tx_tvalid_o = emit && !lb_q;
  assign lb_tvalid_o = emit && lb_q;
  assign tx_tlast_o  = tx_tvalid_o && last_beat;
  assign lb_tlast_o  = lb_tvalid_o && last_beat;

  // R12
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tvalid_o && !tx_tready_i) |=> (tx_tvalid_o && $stable(tx_tdata_o)));
  // R12
  lb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_tvalid_o && !lb_tready_i) |=> (lb_tvalid_o && $stable(lb_tdata_o)));
  // R8
  own_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && mem_wdata_o[USED_B]));
  // R6
  fb_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wptr_q) <= FB_BYTES);
  // R2
  q_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && q_q != $past(q_q)) |-> (q_q == $past(q_q) - QW'(1)));
endmodule

// File: tb/txr_engine_tb.sv
`timescale 1ns/1ps
module txr_engine_tb;
  localparam int NQ = 2;
  localparam int AW = 32;
  // {frag A length, frag B length (0 = single), loopback, backpressure}
  localparam logic [25:0] VEC [5] = '{
    {12'd5,  12'd3, 1'b0, 1'b0},
    {12'd1,  12'd7, 1'b1, 1'b0},
    {12'd12, 12'd0, 1'b0, 1'b0},
    {12'd6,  12'd9, 1'b0, 1'b1},
    {12'd3,  12'd4, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, tx_en, lpbk, clr, rdy, bp;
  logic [NQ-1:0] base_we, q_msk, q_isr;
  logic [NQ*AW-1:0] ring_base;
  logic [1:0] g_msk, stat, isr;
  logic busy, irq, m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [31:0] m_wdata, m_rdata;
  logic [7:0] tx_d, lb_d;
  logic tx_v, tx_l, lb_v, lb_l;

  logic [31:0] mem [1024];
  logic [7:0] cap_d [4096];
  logic cap_lb [4096];
  int cap_n, n_last, n_tests, n_fail, cyc;

  txr_engine #(.NQ(NQ), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_en_i(tx_en), .loopback_i(lpbk),
    .base_we_i(base_we), .ring_base_i(ring_base), .glb_msk_i(g_msk), .q_msk_i(q_msk),
    .stat_clr_i(clr), .busy_o(busy), .stat_o(stat), .isr_o(isr), .q_isr_o(q_isr),
    .irq_o(irq), .mem_req_o(m_req), .mem_we_o(m_we), .mem_addr_o(m_addr),
    .mem_wdata_o(m_wdata), .mem_rdata_i(m_rdata),
    .tx_tdata_o(tx_d), .tx_tvalid_o(tx_v), .tx_tlast_o(tx_l), .tx_tready_i(rdy),
    .lb_tdata_o(lb_d), .lb_tvalid_o(lb_v), .lb_tlast_o(lb_l), .lb_tready_i(rdy)
  );

  always @(posedge clk) begin
    if (m_req) begin
      if (m_we) mem[m_addr[11:2]] <= m_wdata;
      else      m_rdata <= mem[m_addr[11:2]];
    end
  end

  // ready changes at the falling edge; capture uses the value the next rising edge sees
  always @(negedge clk) begin
    rdy = bp ? ~rdy : 1'b1;
    if (rst_n) begin
      if (tx_v && rdy) begin
        cap_d[cap_n] = tx_d; cap_lb[cap_n] = 1'b0; cap_n++;
        if (tx_l) n_last++;
      end
      if (lb_v && rdy) begin
        cap_d[cap_n] = lb_d; cap_lb[cap_n] = 1'b1; cap_n++;
        if (lb_l) n_last++;
      end
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic desc(input int a, input int baddr, input int len, input bit last, input bit wrap);
    logic [31:0] w;
    w = 32'(len);
    w[15] = last;
    w[30] = wrap;
    mem[a >> 2] = 32'(baddr);
    mem[(a >> 2) + 1] = w;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 0; tx_en = 1; lpbk = 0; clr = 0; bp = 0;
    base_we = '0; q_msk = '0; g_msk = '0; ring_base = '0;
    for (int w = 0; w < 1024; w++)
      mem[w] = (w < 256) ? 32'h8000_0000 : {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    cap_n = 0; n_last = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ring_base = {32'h200, 32'h100};
    base_we = '1;
    @(negedge clk);
    base_we = '0;
  endtask

  task automatic run_pass();
    int n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) chk(1'b0, "watchdog", n, 0);
  endtask

  task automatic cmp_bytes(input int at, input int baddr, input int len, input string req);
    int bad = 0, idx = -1;
    for (int i = 0; i < len; i++)
      if (cap_d[at+i] !== pat(baddr+i)) begin bad++; if (idx < 0) idx = i; end
    if (idx < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(cap_d[at+idx]), int'(pat(baddr+idx)));
  endtask

  initial begin
    n_tests = 0; n_fail = 0; rdy = 1'b1;
    do_reset();
    // R13 reset state
    chk(stat == 0 && isr == 0 && q_isr == 0 && !irq, "R13 reset status", int'({stat, isr}), 0);
    chk(!busy && !tx_v && !lb_v, "R13 reset idle", int'({busy, tx_v, lb_v}), 0);

    // table: R7 R8 R11 R12
    for (int v = 0; v < 5; v++) begin
      int la, lb2;
      la = int'(VEC[v][25:14]); lb2 = int'(VEC[v][13:2]);
      do_reset();
      lpbk = VEC[v][1]; bp = VEC[v][0];
      if (lb2 == 0) desc(32'h200, 32'h400, la, 1, 0);
      else begin
        desc(32'h200, 32'h400, la, 0, 0);
        desc(32'h208, 32'h501, lb2, 1, 0);
      end
      run_pass();
      chk(cap_n == la + lb2, "R7 frame length", cap_n, la + lb2);
      cmp_bytes(0, 32'h400, la, "R7 fragment A bytes");
      if (lb2 > 0) cmp_bytes(la, 32'h501, lb2, "R7 fragment B bytes");
      chk(n_last == 1, "R12 one tlast per frame", n_last, 1);
      chk(cap_n > 0 && cap_lb[0] == VEC[v][1], "R11 output channel", int'(cap_lb[0]), int'(VEC[v][1]));
      chk(mem[(32'h200 >> 2) + 1][31] == 1'b1, "R8 first descriptor owned back", 0, 1);
      if (lb2 > 0) chk(mem[(32'h208 >> 2) + 1][31] == 1'b0, "R8 later descriptor untouched", 1, 0);
      chk(stat[0] && isr[0], "R10 complete status", int'(stat[0]), 1);
    end

    // R2 queue order
    do_reset();
    desc(32'h200, 32'h400, 4, 1, 0);
    desc(32'h100, 32'h600, 3, 1, 0);
    run_pass();
    chk(cap_n == 7 && n_last == 2, "R2 two frames", cap_n, 7);
    cmp_bytes(0, 32'h400, 4, "R2 queue 1 first");
    cmp_bytes(4, 32'h600, 3, "R2 queue 0 second");

    // R3 used descriptor ends queue
    do_reset();
    run_pass();
    chk(stat == 2'b10 && isr == 2'b10 && irq, "R3 used status unmasked", int'({stat, isr}), 4'b1010);
    do_reset();
    g_msk = 2'b10;
    run_pass();
    chk(stat[1] && !isr[1] && !irq, "R3 used status masked", int'({stat, isr}), 4'b1000);

    // R4 disabled transmit abandons pass
    do_reset();
    tx_en = 1'b0;
    desc(32'h200, 32'h400, 4, 1, 0);
    run_pass();
    chk(cap_n == 0, "R4 no frame", cap_n, 0);
    chk(mem[(32'h200 >> 2) + 1][31] == 1'b0, "R4 no write-back", 1, 0);
    chk(stat == 2'b00, "R4 later queue not visited", int'(stat), 0);

    // R5 invalid descriptors
    do_reset();
    desc(32'h200, 32'h400, 0, 1, 0);
    desc(32'h208, 32'h400, 2, 1, 0);
    desc(32'h100, 0, 5, 1, 0);
    run_pass();
    chk(cap_n == 0 && stat[0] == 1'b0, "R5 nothing sent", cap_n, 0);
    chk(mem[(32'h208 >> 2) + 1][31] == 1'b0, "R5 queue stopped", 1, 0);

    // R6 oversize fragment is not copied
    do_reset();
    desc(32'h200, 32'h400, 3000, 1, 0);
    desc(32'h100, 32'h600, 2, 1, 0);
    run_pass();
    chk(cap_n == 2 && n_last == 1, "R6 only later frame", cap_n, 2);
    cmp_bytes(0, 32'h600, 2, "R6 no stale bytes");
    chk(mem[(32'h200 >> 2) + 1][31] == 1'b0, "R6 oversize not owned back", 1, 0);

    // R1 R9 consecutive descriptors and wrap
    do_reset();
    desc(32'h200, 32'h400, 2, 1, 0);
    desc(32'h208, 32'h410, 3, 1, 1);
    run_pass();
    chk(cap_n == 5 && n_last == 2, "R1 consecutive descriptors", cap_n, 5);
    cmp_bytes(2, 32'h410, 3, "R1 second descriptor at +8");
    desc(32'h200, 32'h700, 1, 1, 0);
    cap_n = 0; n_last = 0;
    run_pass();
    chk(cap_n == 1, "R9 wrap returns to base", cap_n, 1);
    cmp_bytes(0, 32'h700, 1, "R9 base descriptor data");

    // R10 masks, R13 clear
    do_reset();
    g_msk = 2'b01; q_msk = 2'b01;
    desc(32'h200, 32'h400, 1, 1, 0);
    desc(32'h100, 32'h600, 1, 1, 0);
    run_pass();
    chk(stat[0] && !isr[0], "R10 global complete masked", int'(isr[0]), 0);
    chk(q_isr == 2'b10, "R10 per-queue masks", int'(q_isr), 2);
    chk(irq, "R10 irq from queue bit", int'(irq), 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk(stat == 0 && isr == 0 && q_isr == 0 && !irq, "R13 clear", int'({stat, isr, q_isr}), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end
endmodule